// File: doc/BRIEF.md
# Memory-to-Memory Multi-Cycle Processor

This block is a small processor that has no general-purpose registers. Every arithmetic or logic instruction names two source words and one destination word in a 16-word, 8-bit data memory. The sequencer reads both operands through the memory's single port, one after the other. It keeps the first operand in an internal holding register, combines the two in the ALU and writes the result back through the same port in a separate cycle.

Instructions are 16 bits wide and come from an external instruction memory, which is addressed by a program counter and returns data combinationally. A store-immediate instruction writes an 8-bit constant straight into the data memory. A no-operation instruction only advances the program counter. A halt instruction freezes the processor until reset. A debug port reads any data word combinationally, so a test harness or a monitor can inspect the results.

Top module: `mm_cpu`

## Requirements
- R1: While reset is low and just after it is released, `imem_addr` is 0, `halted` is 0 and every data word reads 0 on the debug port.
- R2: An instruction holds its opcode in [15:14], the destination in [13:10], source1 in [9:6], source2 in [5:2] and the function in [1:0]. Opcode 00 with function 00 stores (Mem[source1] + Mem[source2]) mod 256 in Mem[destination].
- R3: With opcode 00, function 01 stores (Mem[source1] - Mem[source2]) mod 256, function 10 stores the bitwise AND and function 11 stores the bitwise OR.
- R4: Opcode 01 stores the constant held in [9:2] into Mem[[13:10]].
- R5: Opcode 10 leaves every data word unchanged and advances `imem_addr` by one.
- R6: Opcode 11 raises `halted`. From then until reset, `halted` stays high, `imem_addr` holds the address of the halt instruction and no data word changes. Instructions placed after the halt never run.
- R7: When the destination equals one or both sources, the result is computed from the values those words held before the write.
- R8: An opcode 00 instruction takes 4 clock cycles: fetch, read source1, read source2, write. Opcodes 01 and 10 take 2 cycles: fetch, then write or idle. A halt raises `halted` one cycle after its fetch begins. `imem_addr` only ever changes by +1.
- R9: `dbg_data` shows the word at `dbg_addr` in the same cycle, and changing `dbg_addr` has no effect on execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PC_W (8) | Program counter, address into instruction memory |
| imem_data | input | INSTR_W (16) | Instruction word at `imem_addr`, combinational |
| halted | output | 1 | High once a halt instruction has been fetched |
| dbg_addr | input | AW (4) | Data memory word to observe |
| dbg_data | output | DW (8) | Contents of the word at `dbg_addr` |

## Verification
Suppose the sequencer skips or repeats a state, or latches the holding register at the wrong time. Then the cycle count from reset release to `halted` is wrong as soon as the program ends, and the final data words differ from those a model execution gives. A wrong destination or operand decode usually corrupts a word that the debug sweep reads after halt. A write issued in a read phase breaks the rule that a destination equal to a source uses old values. The bench covers this with directed programs in which a destination is also a source. A program counter that drifts after halt shows at `imem_addr` within a few cycles.

// File: rtl/mm_pkg.sv
package mm_pkg;
   typedef enum logic [2:0] {
      ST_FETCH = 3'd0,
      ST_RD1   = 3'd1,
      ST_RD2   = 3'd2,
      ST_WR    = 3'd3,
      ST_HALT  = 3'd4
   } mm_state_e;

   localparam logic [1:0] OP_ALU  = 2'b00;
   localparam logic [1:0] OP_IMM  = 2'b01;
   localparam logic [1:0] OP_NOP  = 2'b10;
   localparam logic [1:0] OP_HALT = 2'b11;

   localparam logic [1:0] FN_ADD = 2'b00;
   localparam logic [1:0] FN_SUB = 2'b01;
   localparam logic [1:0] FN_AND = 2'b10;
   localparam logic [1:0] FN_OR  = 2'b11;
endpackage

// File: rtl/mm_alu.sv
module mm_alu #(
   parameter int DW        = 8,
   parameter bit SUB_BY_ADD = 1'b0
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [1:0]    fn,
   output logic [DW-1:0] y
);
   import mm_pkg::*;

   logic [DW-1:0] diff;

   generate
      if (SUB_BY_ADD) begin : g_sub_add
         assign diff = a + (~b) + {{(DW-1){1'b0}}, 1'b1};
      end else begin : g_sub_direct
         assign diff = a - b;
      end
   endgenerate

   always_comb begin
      case (fn)
         FN_ADD:  y = a + b;
         FN_SUB:  y = diff;
         FN_AND:  y = a & b;
         default: y = a | b;
      endcase
   end
endmodule

// File: rtl/mm_dmem.sv
module mm_dmem #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [AW-1:0] dbg_addr,
   output logic [DW-1:0] dbg_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n)
               words[i] <= '0;
            else if (we && addr == AW'(i))
               words[i] <= wdata;
         end
      end
   endgenerate

   assign rdata    = words[addr];
   assign dbg_data = words[dbg_addr];
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
   parameter int DW      = 8,
   parameter int AW      = 4,
   parameter int PC_W    = 8,
   parameter int INSTR_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] imem_data,
   output logic [PC_W-1:0]    pc,
   output mm_pkg::mm_state_e  st,
   output logic [AW-1:0]      dm_addr,
   output logic               dm_we,
   output logic [DW-1:0]      dm_wdata,
   input  logic [DW-1:0]      dm_rdata,
   output logic [DW-1:0]      hold,
   output logic [DW-1:0]      op2,
   output logic [1:0]         fn,
   input  logic [DW-1:0]      alu_y
);
   import mm_pkg::*;

   localparam int OP_LSB  = INSTR_W - 2;
   localparam int DST_LSB = OP_LSB - AW;
   localparam int S1_LSB  = DST_LSB - AW;
   localparam int S2_LSB  = S1_LSB - AW;
   localparam int IMM_LSB = 2;

   logic [INSTR_W-1:0] ir;
   logic [1:0]         op;
   logic [AW-1:0]      dst, src1, src2;
   logic [DW-1:0]      imm;

   assign op   = ir[INSTR_W-1:OP_LSB];
   assign dst  = ir[DST_LSB +: AW];
   assign src1 = ir[S1_LSB +: AW];
   assign src2 = ir[S2_LSB +: AW];
   assign imm  = ir[IMM_LSB +: DW];
   assign fn   = ir[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_FETCH;
         pc   <= '0;
         ir   <= '0;
         hold <= '0;
         op2  <= '0;
      end else begin
         case (st)
            ST_FETCH: begin
               ir <= imem_data;
               case (imem_data[INSTR_W-1:OP_LSB])
                  OP_ALU:  st <= ST_RD1;
                  OP_HALT: st <= ST_HALT;
                  default: st <= ST_WR;
               endcase
            end
            ST_RD1: begin
               hold <= dm_rdata;
               st   <= ST_RD2;
            end
            ST_RD2: begin
               op2 <= dm_rdata;
               st  <= ST_WR;
            end
            ST_WR: begin
               pc <= pc + 1'b1;
               st <= ST_FETCH;
            end
            default: st <= ST_HALT;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_RD1:  dm_addr = src1;
         ST_RD2:  dm_addr = src2;
         default: dm_addr = dst;
      endcase
   end

   assign dm_we    = (st == ST_WR) && (op == OP_ALU || op == OP_IMM);
   assign dm_wdata = (op == OP_IMM) ? imm : alu_y;
endmodule

// File: rtl/mm_cpu.sv
module mm_cpu #(
   parameter int DW         = 8,
   parameter int AW         = 4,
   parameter int PC_W       = 8,
   parameter int INSTR_W    = 16,
   parameter bit SUB_BY_ADD = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PC_W-1:0]    imem_addr,
   input  logic [INSTR_W-1:0] imem_data,
   output logic               halted,
   input  logic [AW-1:0]      dbg_addr,
   output logic [DW-1:0]      dbg_data
);
   import mm_pkg::*;

   localparam int FIELD_BITS = 2 + 3 * AW + 2;
   localparam int IMM_BITS   = INSTR_W - 4 - AW;

   generate
      if (FIELD_BITS != INSTR_W) begin : g_bad_fields
         $fatal(1, "instruction width must hold opcode, three addresses and function");
      end
      if (IMM_BITS != DW) begin : g_bad_imm
         $fatal(1, "immediate field width must equal data width");
      end
   endgenerate

   mm_state_e     st;
   logic [AW-1:0] dm_addr;
   logic          dm_we;
   logic [DW-1:0] dm_wdata, dm_rdata, hold, op2, alu_y;
   logic [1:0]    fn;

   mm_ctrl #(.DW(DW), .AW(AW), .PC_W(PC_W), .INSTR_W(INSTR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .imem_data(imem_data), .pc(imem_addr),
      .st(st), .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata),
      .dm_rdata(dm_rdata), .hold(hold), .op2(op2), .fn(fn), .alu_y(alu_y)
   );

   mm_alu #(.DW(DW), .SUB_BY_ADD(SUB_BY_ADD)) u_alu (
      .a(hold), .b(op2), .fn(fn), .y(alu_y)
   );

   mm_dmem #(.DW(DW), .AW(AW)) u_dmem (
      .clk(clk), .rst_n(rst_n), .addr(dm_addr), .we(dm_we),
      .wdata(dm_wdata), .rdata(dm_rdata), .dbg_addr(dbg_addr),
      .dbg_data(dbg_data)
   );

   assign halted = (st == ST_HALT);
endmodule

// File: rtl/mm_cpu_chk.sv
module mm_cpu_chk #(
   parameter int PC_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halted,
   input logic [PC_W-1:0]   imem_addr,
   input logic              dm_we,
   input mm_pkg::mm_state_e st
);
   import mm_pkg::*;

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R6
   AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr)); // R6
   AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !dm_we); // R6
   AST_PC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(imem_addr) |-> imem_addr == $past(imem_addr) + 1'b1); // R8
   AST_WRITE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      dm_we |=> (st == ST_FETCH && !dm_we)); // R8
   AST_RD2_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD2) |=> (st == ST_WR)); // R7
endmodule

bind mm_cpu mm_cpu_chk #(.PC_W(PC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .halted(halted), .imem_addr(imem_addr),
   .dm_we(dm_we), .st(st)
);

// File: tb/sim_mm_cpu.sv
module sim_mm_cpu;
   localparam int DW = 8, AW = 4, PC_W = 8, INSTR_W = 16;
   localparam int DEPTH = 1 << AW;
   localparam logic [15:0] I_NOP  = 16'h8000;
   localparam logic [15:0] I_HALT = 16'hC000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [PC_W-1:0]    imem_addr;
   logic [INSTR_W-1:0] imem_data;
   logic               halted;
   logic [AW-1:0]      dbg_addr = '0;
   logic [DW-1:0]      dbg_data;

   logic [15:0] prog [256];
   logic [7:0]  ref_mem [DEPTH];
   int          ref_cycles;
   int          ref_halt_pc;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          rand_dbg = 1'b0;

   always #4 clk = ~clk;

   assign imem_data = prog[imem_addr];

   mm_cpu #(.DW(DW), .AW(AW), .PC_W(PC_W), .INSTR_W(INSTR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
      .halted(halted), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
   );

   always @(negedge clk) if (rand_dbg) dbg_addr <= AW'($urandom);

   function automatic logic [15:0] enc_alu(input logic [1:0] f, input int d, input int a, input int b);
      return {2'b00, 4'(d), 4'(a), 4'(b), f};
   endfunction

   function automatic logic [15:0] enc_imm(input int d, input int v);
      return {2'b01, 4'(d), 8'(v), 2'b00};
   endfunction

   function automatic logic [7:0] alu_ref(input logic [1:0] f, input logic [7:0] a, input logic [7:0] b);
      case (f)
         2'b00:   return a + b;
         2'b01:   return a - b;
         2'b10:   return a & b;
         default: return a | b;
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) prog[i] = I_HALT;
   endtask

   task automatic model();
      int pc = 0;
      logic [15:0] ins;
      logic [7:0] a, b;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'd0;
      ref_cycles = 0;
      while (pc < 256) begin
         ins = prog[pc];
         case (ins[15:14])
            2'b11: begin ref_cycles += 1; break; end
            2'b00: begin
               a = ref_mem[ins[9:6]];
               b = ref_mem[ins[5:2]];
               ref_mem[ins[13:10]] = alu_ref(ins[1:0], a, b);
               ref_cycles += 4;
            end
            2'b01: begin ref_mem[ins[13:10]] = ins[9:2]; ref_cycles += 2; end
            default: ref_cycles += 2;
         endcase
         pc++;
      end
      ref_halt_pc = pc;
   endtask

   task automatic run_and_check(input string req);
      int cyc = 0;
      bit to = 1'b0;
      model();
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      rand_dbg = 1'b1;
      forever begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (halted) break;
         if (cyc > 5000) begin to = 1'b1; break; end
      end
      rand_dbg = 1'b0;
      if (to) begin
         n_checks++; n_fail++;
         $display("FAIL R8 watchdog: actual timeout expected halt");
         return;
      end
      check("R8", {req, " cycles to halt"}, cyc, ref_cycles);
      check("R6", {req, " pc at halt"}, int'(imem_addr), ref_halt_pc);
      repeat (5) @(negedge clk);
      check("R6", {req, " halted held"}, int'(halted), 1);
      check("R6", {req, " pc held"}, int'(imem_addr), ref_halt_pc);
      for (int i = 0; i < DEPTH; i++) begin
         dbg_addr = AW'(i);
         #1;
         check(req, $sformatf("word %0d (R9 debug read)", i), int'(dbg_data), int'(ref_mem[i]));
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      clear_prog();
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "pc in reset", int'(imem_addr), 0);
      check("R1", "halted in reset", int'(halted), 0);
      for (int i = 0; i < DEPTH; i++) begin
         dbg_addr = AW'(i);
         #1;
         check("R1", $sformatf("word %0d in reset", i), int'(dbg_data), 0);
      end

      // R2/R4: 2 + 3 = 5
      clear_prog();
      prog[0] = enc_imm(1, 2);
      prog[1] = enc_imm(2, 3);
      prog[2] = enc_alu(2'b00, 0, 1, 2);
      run_and_check("R2");

      // R3: sub wrap, and, or, add wrap
      clear_prog();
      prog[0] = enc_imm(3, 0);
      prog[1] = enc_imm(4, 1);
      prog[2] = enc_alu(2'b01, 5, 3, 4);
      prog[3] = enc_imm(6, 8'hC3);
      prog[4] = enc_imm(7, 8'h5A);
      prog[5] = enc_alu(2'b10, 8, 6, 7);
      prog[6] = enc_alu(2'b11, 9, 6, 7);
      prog[7] = enc_imm(10, 200);
      prog[8] = enc_imm(11, 100);
      prog[9] = enc_alu(2'b00, 12, 10, 11);
      run_and_check("R3");

      // R7: destination equals source
      clear_prog();
      prog[0] = enc_imm(6, 7);
      prog[1] = enc_alu(2'b00, 6, 6, 6);
      prog[2] = enc_imm(2, 20);
      prog[3] = enc_alu(2'b01, 2, 2, 6);
      prog[4] = enc_alu(2'b01, 6, 2, 6);
      run_and_check("R7");

      // R5/R6: nops, then instructions after halt that must not run
      clear_prog();
      prog[0] = enc_imm(15, 9);
      prog[1] = I_NOP;
      prog[2] = I_NOP;
      prog[3] = enc_alu(2'b00, 14, 15, 15);
      prog[4] = I_HALT;
      prog[5] = enc_imm(15, 77);
      prog[6] = enc_imm(0, 1);
      run_and_check("R5");

      // halt as first instruction
      clear_prog();
      run_and_check("R6");

      // constrained random programs
      for (int t = 0; t < 12; t++) begin
         int len = 1 + int'($urandom % 40);
         clear_prog();
         for (int k = 0; k < len; k++) begin
            case ($urandom % 3)
               0: prog[k] = enc_imm(int'($urandom % 16), int'($urandom % 256));
               1: prog[k] = I_NOP;
               default: prog[k] = enc_alu(2'($urandom), int'($urandom % 16),
                                          int'($urandom % 16), int'($urandom % 16));
            endcase
         end
         run_and_check("R3");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1600000;
      n_checks++; n_fail++;
      $display("FAIL R8 global watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule